// File: doc/BRIEF.md
# Deferred Soft-Error Reporting Tracker

This block sits beside a pipeline's parity checkers and decides when a detected fault really has to become a machine-check. It does not raise an error the moment a parity checker fires. Instead it marks the affected in-flight instruction as possibly incorrect, and lets that mark follow the instruction to commit. It can also carry the mark into the destination register's shadow bit. The error is raised only if the suspect value can still reach the program's visible results.

A fault on a squashed instruction is dropped. So is a fault on an instruction whose result is never consumed, and a fault on a class of instruction that cannot change results. This removes false detected-unrecoverable errors.

A live mode input picks the point at which the mark turns into an error:
- at commit of the instruction,
- at a read of the tainted register,
- at any store that writes out a tainted register,
- only at I/O stores that write out a tainted register.

The error output is a one-cycle pulse that names the culprit, either the instruction tag or the register index.

Top module: `pibit_err_tracker`

## Requirements
- R1: A synchronous active-high reset clears every instruction mark and every register mark, and holds `err_valid` low; no mark set before reset can cause an error afterwards.
- R2: A commit with `cm_wrong_path` or `cm_pred_false` set raises no error, writes no register mark even with `cm_wr_en` high, and frees the tag's mark.
- R3: With `mode` = 0 (report at commit), a commit whose tag carries a mark produces `err_valid` with `err_src` = 0 and `err_id` = the tag. The tag's mark is cleared by the commit. A detection and a commit of the same tag in the same cycle count as marked.
- R4: A detection whose `det_cls` is 1 (no-op), 2 (prefetch) or 3 (prediction hint) sets no mark; class 0 (ordinary) does.
- R5: With `mode` = 1 (report at register read), a marked commit with `cm_wr_en` raises no error but marks register `cm_wr_reg`. Each later `rd_valid` of a marked register produces `err_valid` with `err_src` = 1 and `err_id` = the register index.
- R6: A marked register that is overwritten before any read never causes an error.
- R7: A committed write from an unmarked instruction clears the destination register's mark.
- R8: With `mode` = 2 (report at store), any `st_valid` whose source register `st_reg` is marked produces an error with `err_src` = 1 and `err_id` = `st_reg`. In this mode, register reads and commits raise nothing.
- R9: With `mode` = 3 (report at I/O), only a `st_valid` with `st_is_io` = 1 and a marked source register raises an error; ordinary stores do not.
- R10: `err_valid` rises in the cycle after the clock edge that sampled the triggering event, and it lasts one cycle for each event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Reporting point: 0 commit, 1 register read, 2 store, 3 I/O |
| det_valid | input | 1 | A parity checker flagged an in-flight instruction |
| det_tag | input | TAG_W | Tag of the flagged instruction |
| det_cls | input | 3 | Class: 0 ordinary, 1 no-op, 2 prefetch, 3 hint |
| cm_valid | input | 1 | An instruction leaves the pipeline |
| cm_tag | input | TAG_W | Tag of the leaving instruction |
| cm_wrong_path | input | 1 | Leaving instruction was on a mispredicted path |
| cm_pred_false | input | 1 | Leaving instruction had a false predicate |
| cm_wr_en | input | 1 | Leaving instruction writes a register |
| cm_wr_reg | input | REG_W | Destination register index |
| rd_valid | input | 1 | A register is read as a source operand |
| rd_reg | input | REG_W | Index of the register read |
| st_valid | input | 1 | A store commits |
| st_is_io | input | 1 | The committing store targets I/O space |
| st_reg | input | REG_W | Register supplying the store data |
| err_valid | output | 1 | One-cycle error pulse |
| err_src | output | 1 | 0: `err_id` is a tag, 1: `err_id` is a register |
| err_id | output | ID_W | Tag or register responsible for the error |

## Verification
The embedded assertions check several rules on every cycle:
- anti-mark classes never create a new mark;
- a clean write always clears its register's mark;
- squashed commits never raise an error;
- in I/O mode, ordinary stores never raise an error;
- the error source always agrees with the mode that was sampled.

Other behaviours need a particular sequence of events, and only the bench's scenarios show them:
- a mark travelling from detection through commit into a register;
- an overwrite hiding a fault before any read;
- repeated reads each reporting;
- reset wiping marks that are still pending.

// File: rtl/pibit_pkg.sv
package pibit_pkg;

    localparam int DEF_TAG_W = 4;
    localparam int DEF_REG_W = 4;

    typedef enum logic [1:0] {
        MODE_COMMIT  = 2'd0,
        MODE_REGREAD = 2'd1,
        MODE_STORE   = 2'd2,
        MODE_IO      = 2'd3
    } report_mode_e;

    typedef enum logic [2:0] {
        CLS_ORDINARY = 3'd0,
        CLS_NOP      = 3'd1,
        CLS_PREFETCH = 3'd2,
        CLS_HINT     = 3'd3
    } insn_cls_e;

    // Classes whose results cannot alter program output.
    function automatic logic is_neutral(input logic [2:0] cls);
        return (cls == CLS_NOP) || (cls == CLS_PREFETCH) || (cls == CLS_HINT);
    endfunction

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pibit_tag_table.sv
module pibit_tag_table
    import pibit_pkg::*;
#(
    parameter int TAG_W = DEF_TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det_valid,
    input  logic [TAG_W-1:0] det_tag,
    input  logic [2:0]       det_cls,
    input  logic             cm_valid,
    input  logic [TAG_W-1:0] cm_tag,
    output logic             cm_marked
);
    localparam int ENTRIES = 1 << TAG_W;

    logic [ENTRIES-1:0] mark_q;
    logic               set_hit;

    assign set_hit   = det_valid && !is_neutral(det_cls);
    assign cm_marked = cm_valid && (mark_q[cm_tag] || (set_hit && det_tag == cm_tag));

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= '0;
        end else begin
            if (set_hit)
                mark_q[det_tag] <= 1'b1;
            if (cm_valid)
                mark_q[cm_tag] <= 1'b0;
        end
    end

    // R4
    neutral_no_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (det_valid && is_neutral(det_cls) && !mark_q[det_tag])
            |=> !mark_q[$past(det_tag)]);

endmodule

// File: rtl/pibit_reg_tracker.sv
module pibit_reg_tracker
    import pibit_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             wr_mark,
    input  logic [REG_W-1:0] rd_reg,
    input  logic [REG_W-1:0] st_reg,
    output logic             rd_marked,
    output logic             st_marked
);
    localparam int NREGS = 1 << REG_W;

    logic [NREGS-1:0] rmark_q;

    assign rd_marked = rmark_q[rd_reg];
    assign st_marked = rmark_q[st_reg];

    always_ff @(posedge clk) begin
        if (rst)
            rmark_q <= '0;
        else if (wr_en)
            rmark_q[wr_reg] <= wr_mark;
    end

    // R7
    clean_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_mark) |=> !rmark_q[$past(wr_reg)]);

endmodule

// File: rtl/pibit_err_tracker.sv
module pibit_err_tracker
    import pibit_pkg::*;
#(
    parameter int TAG_W = DEF_TAG_W,
    parameter int REG_W = DEF_REG_W,
    localparam int ID_W = max_w(TAG_W, REG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             det_valid,
    input  logic [TAG_W-1:0] det_tag,
    input  logic [2:0]       det_cls,
    input  logic             cm_valid,
    input  logic [TAG_W-1:0] cm_tag,
    input  logic             cm_wrong_path,
    input  logic             cm_pred_false,
    input  logic             cm_wr_en,
    input  logic [REG_W-1:0] cm_wr_reg,
    input  logic             rd_valid,
    input  logic [REG_W-1:0] rd_reg,
    input  logic             st_valid,
    input  logic             st_is_io,
    input  logic [REG_W-1:0] st_reg,
    output logic             err_valid,
    output logic             err_src,
    output logic [ID_W-1:0]  err_id
);
    report_mode_e mode_e;
    logic         cm_marked, squash, live_mark, reg_wr;
    logic         rd_marked, st_marked;
    logic         ev_hit, ev_src;
    logic [ID_W-1:0] ev_id;

    assign mode_e    = report_mode_e'(mode);
    assign squash    = cm_wrong_path || cm_pred_false;
    assign live_mark = cm_marked && !squash;
    assign reg_wr    = cm_valid && !squash && cm_wr_en;

    pibit_tag_table #(.TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .det_valid (det_valid),
        .det_tag   (det_tag),
        .det_cls   (det_cls),
        .cm_valid  (cm_valid),
        .cm_tag    (cm_tag),
        .cm_marked (cm_marked)
    );

    pibit_reg_tracker #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .wr_reg    (cm_wr_reg),
        .wr_mark   (live_mark),
        .rd_reg    (rd_reg),
        .st_reg    (st_reg),
        .rd_marked (rd_marked),
        .st_marked (st_marked)
    );

    always_comb begin
        ev_hit = 1'b0;
        ev_src = 1'b1;
        ev_id  = '0;
        unique case (mode_e)
            MODE_COMMIT: begin
                ev_hit = cm_valid && live_mark;
                ev_src = 1'b0;
                ev_id  = ID_W'(cm_tag);
            end
            MODE_REGREAD: begin
                ev_hit = rd_valid && rd_marked;
                ev_id  = ID_W'(rd_reg);
            end
            MODE_STORE: begin
                ev_hit = st_valid && st_marked;
                ev_id  = ID_W'(st_reg);
            end
            MODE_IO: begin
                ev_hit = st_valid && st_is_io && st_marked;
                ev_id  = ID_W'(st_reg);
            end
            default: ev_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_src   <= 1'b0;
            err_id    <= '0;
        end else begin
            err_valid <= ev_hit;
            err_src   <= ev_src;
            err_id    <= ev_id;
        end
    end

    // R2
    squash_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_COMMIT && cm_valid && squash && !rd_valid && !st_valid)
            |=> !err_valid);

    // R9
    plain_store_io_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_IO && st_valid && !st_is_io) |=> !err_valid);

    // R3
    src_matches_mode_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_src == ($past(mode) != 2'd0)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !err_valid);

endmodule

// File: tb/pibit_err_tracker_test.sv
module pibit_err_tracker_test;
    import pibit_pkg::*;

    localparam int TW = 4;
    localparam int RW = 4;
    localparam int IW = 4;

    typedef struct packed {
        logic [1:0]    mode;
        logic          dv;
        logic [TW-1:0] dtag;
        logic [2:0]    dcls;
        logic          cv;
        logic [TW-1:0] ctag;
        logic          cwp;
        logic          cpf;
        logic          cwe;
        logic [RW-1:0] creg;
        logic          rv;
        logic [RW-1:0] rreg;
        logic          sv;
        logic          sio;
        logic [RW-1:0] sreg;
        logic          ev;
        logic          esrc;
        logic [IW-1:0] eid;
    } vec_t;

    function automatic vec_t mk(int md, int dv, int dt, int dc, int cv, int ct, int wp,
                                int pf, int we, int cr, int rv, int rr, int sv, int sio,
                                int sr, int ev, int es, int ei);
        vec_t v;
        v.mode = 2'(md); v.dv = 1'(dv); v.dtag = TW'(dt); v.dcls = 3'(dc);
        v.cv = 1'(cv); v.ctag = TW'(ct); v.cwp = 1'(wp); v.cpf = 1'(pf);
        v.cwe = 1'(we); v.creg = RW'(cr); v.rv = 1'(rv); v.rreg = RW'(rr);
        v.sv = 1'(sv); v.sio = 1'(sio); v.sreg = RW'(sr);
        v.ev = 1'(ev); v.esrc = 1'(es); v.eid = IW'(ei);
        return v;
    endfunction

    localparam int NV = 31;
    //                 md dv dt dc cv ct wp pf we cr rv rr sv io sr ev es ei
    localparam vec_t VECS [NV] = '{
        mk(0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3),
        mk(0, 1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 1, 7, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 1, 7, 0, 1, 7, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(0, 1, 9, 0, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 9),
        mk(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 1, 2, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, 1, 1, 4),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, 1, 1, 4),
        mk(1, 0, 0, 0, 1, 1, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0),
        mk(1, 1, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 1, 8, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 1, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0),
        mk(2, 1, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(2, 0, 0, 0, 1, 10, 0, 0, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0, 0, 0, 0, 0),
        mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6, 1, 1, 6),
        mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6, 0, 0, 0),
        mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 6, 1, 1, 6),
        mk(3, 1, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(3, 0, 0, 0, 1, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 1, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 1, 13, 1, 0, 1, 8, 0, 0, 0, 0, 0, 0, 0, 0),
        mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0, 0, 0)
    };
    localparam string VREQ [NV] = '{
        "R4", "R3", "R4", "R4", "R2", "R2", "R4", "R2", "R3", "R3",
        "R5", "R5", "R5", "R5", "R7", "R7", "R6", "R6", "R6", "R6",
        "R8", "R8", "R8", "R8", "R9", "R9", "R9", "R9", "R2", "R2", "R2"
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode;
    logic det_valid, cm_valid, cm_wrong_path, cm_pred_false, cm_wr_en;
    logic rd_valid, st_valid, st_is_io;
    logic [TW-1:0] det_tag, cm_tag;
    logic [2:0] det_cls;
    logic [RW-1:0] cm_wr_reg, rd_reg, st_reg;
    logic err_valid, err_src;
    logic [IW-1:0] err_id;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pibit_err_tracker #(.TAG_W(TW), .REG_W(RW)) uut (
        .clk(clk), .rst(rst), .mode(mode),
        .det_valid(det_valid), .det_tag(det_tag), .det_cls(det_cls),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_wrong_path(cm_wrong_path),
        .cm_pred_false(cm_pred_false), .cm_wr_en(cm_wr_en), .cm_wr_reg(cm_wr_reg),
        .rd_valid(rd_valid), .rd_reg(rd_reg),
        .st_valid(st_valid), .st_is_io(st_is_io), .st_reg(st_reg),
        .err_valid(err_valid), .err_src(err_src), .err_id(err_id)
    );

    task automatic drive(input vec_t v);
        mode = v.mode; det_valid = v.dv; det_tag = v.dtag; det_cls = v.dcls;
        cm_valid = v.cv; cm_tag = v.ctag; cm_wrong_path = v.cwp; cm_pred_false = v.cpf;
        cm_wr_en = v.cwe; cm_wr_reg = v.creg; rd_valid = v.rv; rd_reg = v.rreg;
        st_valid = v.sv; st_is_io = v.sio; st_reg = v.sreg;
    endtask

    task automatic expect_err(input string req, input logic ev, input logic es,
                              input logic [IW-1:0] ei);
        checks++;
        if (err_valid !== ev || (ev && (err_src !== es || err_id !== ei))) begin
            errors++;
            $display("FAIL %s: got valid=%0b src=%0b id=%0d, expected valid=%0b src=%0b id=%0d",
                     req, err_valid, err_src, err_id, ev, es, ei);
        end
    endtask

    function automatic vec_t idle(int md);
        return mk(md, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive(idle(0));
        repeat (3) @(negedge clk);
        expect_err("R1", 1'b0, 1'b0, '0);   // R1 reset state
        rst = 1'b0;

        // Vector table, one event per cycle, result seen one cycle later (R10)
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            expect_err(VREQ[i], VECS[i].ev, VECS[i].esrc, VECS[i].eid);
            if (i + 1 < NV) drive(VECS[i + 1]);
            else drive(idle(0));
        end

        // R10: single pulse per event
        drive(mk(0, 1, 15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        drive(mk(0, 0, 0, 0, 1, 15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        drive(idle(0));
        expect_err("R10", 1'b1, 1'b0, 4'd15);
        @(negedge clk);
        expect_err("R10", 1'b0, 1'b0, '0);

        // R1: reset wipes pending instruction and register marks
        drive(mk(1, 1, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        drive(mk(1, 1, 14, 0, 1, 12, 0, 0, 1, 7, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        drive(idle(1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_err("R1", 1'b0, 1'b0, '0);
        drive(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        drive(mk(0, 0, 0, 0, 1, 14, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        expect_err("R1", 1'b0, 1'b0, '0);
        @(negedge clk);
        drive(idle(0));
        expect_err("R1", 1'b0, 1'b0, '0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule